// File: doc/BRIEF.md
# Pattern-Masked Waveform Readout

This block reads out a bank of digitizer channels after a trigger. Every channel writes its samples into a short ring history. A trigger arrives with a 64-bit selection pattern, which upstream cluster logic produces and which changes from event to event. For each channel whose pattern bit is set, the block sends a fixed window of ten samples taken from that channel's history. Channels whose bit is clear produce no words, so the data volume follows the pattern and not the size of the bank.

The output is one ready/valid stream of typed words. Bits [13:12] of each word give its kind: 00 event header, 01 channel header, 10 sample, 11 trailer. The payload sits in bits [11:0]. A programmable lookback places the window relative to the newest stored sample. While an event is being sent, the history is frozen. One further trigger can be held until the current event ends; any trigger beyond that is dropped and flagged.

Top module: `pmask_wave_readout`

## Requirements
- R1: After reset, `out_valid` and `overflow` are low.
- R2: An accepted trigger starts an event with a header word (kind 00) whose payload is the effective lookback. The event ends with a trailer word (kind 11) whose payload is the number of channels sent.
- R3: Every channel whose pattern bit is set is sent once, in ascending index order. Each channel starts with a channel-header word (kind 01) that carries its index in payload bits [5:0].
- R4: Each channel header is followed by exactly ten sample words (kind 10, sample in bits [11:0]), oldest first. The first sample is L samples older than the newest stored sample, and the last is L-9 samples older, where L is the effective lookback.
- R5: A lookback input below 9 is raised to 9. Values from 9 to 15 are used as given. The lookback is captured together with its trigger.
- R6: An all-zero pattern produces only the event header and a trailer with count 0.
- R7: While `out_valid` is high and `out_ready` is low, the word on `out_data` and `out_valid` stay unchanged.
- R8: A trigger that arrives while an event is being sent is held in a one-deep slot. Its event starts right after the current trailer and uses its own pattern and lookback.
- R9: A trigger that arrives while the slot is already full is discarded. `overflow` is high for exactly the next cycle.
- R10: Samples are stored only while no event is in progress. A sample presented in the same cycle as a trigger accepted from idle is stored and becomes the newest sample. Samples presented during an event are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One new sample for every channel this cycle |
| smp_data | input | 768 | Channel c sample in bits [c*12 +: 12] |
| trig | input | 1 | Trigger pulse, one cycle |
| trig_mask | input | 64 | Channel-selection pattern for this trigger |
| lookback | input | 4 | Age of the first window sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 14 | Kind in [13:12], payload in [11:0] |
| overflow | output | 1 | A trigger was discarded in the previous cycle |

## Verification
The assertions assume that every trigger is a single-cycle pulse and that `out_ready` may change freely from cycle to cycle. Under those assumptions they check the held-word stability, the ascending channel order, the frozen history during events and when overflow may occur. The stimulus fills the history with at least 16 samples before the first trigger, so every window reads written data. It drives sample bursts only when the stream is idle, except in the directed cases that test the dropping of samples and the inclusion of a sample that arrives with the trigger. Random patterns, lookbacks and ready gaps are drawn from a fixed seed, alongside directed cases for channels 0 and 63, the all-ones and all-zero patterns, lookback clamping, and a held trigger followed by a discarded one.

// File: rtl/pmask_wave_readout.sv
module pmask_wave_readout #(
  parameter int NCH    = 64,
  parameter int SW     = 12,
  parameter int NSAMP  = 10,
  parameter int HDEPTH = 16,
  localparam int CW = $clog2(NCH),
  localparam int AW = $clog2(HDEPTH),
  localparam int IW = $clog2(NSAMP),
  localparam int OW = SW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic              trig,
  input  logic [NCH-1:0]    trig_mask,
  input  logic [AW-1:0]     lookback,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OW-1:0]     out_data,
  output logic              overflow
);

  typedef enum logic [2:0] {S_IDLE, S_EVH, S_CHH, S_SMP, S_TRL} st_t;

  st_t            st;
  logic [NCH-1:0] mask_q, pend_mask, rest;
  logic [AW-1:0]  lb_q, pend_lb, lb_in, wptr, rd_addr;
  logic [IW-1:0]  idx;
  logic [CW:0]    cnt;
  logic [CW-1:0]  cur, last_ch;
  logic           pend_v, have_ch, hs, trl_done;
  logic [SW-1:0]  hist [NCH][HDEPTH];

  assign out_valid = (st != S_IDLE);
  assign hs        = out_valid && out_ready;
  assign trl_done  = (st == S_TRL) && hs;
  assign lb_in     = (lookback < AW'(NSAMP-1)) ? AW'(NSAMP-1) : lookback;
  assign rest      = mask_q & ~(NCH'(1) << cur);
  assign rd_addr   = wptr - AW'(1) - lb_q + AW'(idx);

  always_comb begin
    cur = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (mask_q[i]) cur = CW'(i);
  end

  always_comb begin
    case (st)
      S_EVH:   out_data = {2'b00, SW'(lb_q)};
      S_CHH:   out_data = {2'b01, SW'(cur)};
      S_SMP:   out_data = {2'b10, hist[cur][rd_addr]};
      S_TRL:   out_data = {2'b11, SW'(cnt)};
      default: out_data = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (st == S_IDLE && smp_en)
      for (int c = 0; c < NCH; c++)
        hist[c][wptr] <= smp_data[c*SW +: SW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mask_q    <= '0;
      lb_q      <= '0;
      idx       <= '0;
      cnt       <= '0;
      wptr      <= '0;
      pend_v    <= 1'b0;
      pend_mask <= '0;
      pend_lb   <= '0;
      overflow  <= 1'b0;
      last_ch   <= '0;
      have_ch   <= 1'b0;
    end else begin
      overflow <= 1'b0;
      if (st == S_IDLE && smp_en) wptr <= wptr + AW'(1);
      case (st)
        S_IDLE: if (trig) begin
          mask_q <= trig_mask; lb_q <= lb_in; cnt <= '0; have_ch <= 1'b0; st <= S_EVH;
        end
        S_EVH: if (hs) st <= (mask_q != '0) ? S_CHH : S_TRL;
        S_CHH: if (hs) begin
          idx <= '0; last_ch <= cur; have_ch <= 1'b1; st <= S_SMP;
        end
        S_SMP: if (hs) begin
          if (idx == IW'(NSAMP-1)) begin
            mask_q <= rest;
            cnt    <= cnt + 1'b1;
            st     <= (rest != '0) ? S_CHH : S_TRL;
          end else idx <= idx + 1'b1;
        end
        S_TRL: if (hs) begin
          if (pend_v) begin
            mask_q <= pend_mask; lb_q <= pend_lb; cnt <= '0; have_ch <= 1'b0; st <= S_EVH;
            pend_v <= trig;
            if (trig) begin pend_mask <= trig_mask; pend_lb <= lb_in; end
          end else if (trig) begin
            mask_q <= trig_mask; lb_q <= lb_in; cnt <= '0; have_ch <= 1'b0; st <= S_EVH;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (st != S_IDLE && trig && !trl_done) begin
        if (!pend_v) begin
          pend_v <= 1'b1; pend_mask <= trig_mask; pend_lb <= lb_in;
        end else overflow <= 1'b1;
      end
    end
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHH && have_ch) |-> (cur > last_ch));

  p_trailer_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRL) |-> (mask_q == '0));

  p_frozen_hist_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(wptr));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> pend_v);

endmodule

// File: tb/pmask_wave_readout_bench.sv
`timescale 1ns/1ps
module pmask_wave_readout_bench;
  localparam int NCH = 64, SW = 12, OW = 14;

  logic clk = 0, rst_n = 0;
  logic smp_en = 0, trig = 0, out_ready = 0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic [NCH-1:0] trig_mask = '0;
  logic [3:0] lookback = '0;
  logic out_valid, overflow;
  logic [OW-1:0] out_data;

  pmask_wave_readout u_pmask_wave_readout (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data),
    .trig(trig), .trig_mask(trig_mask), .lookback(lookback),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .overflow(overflow));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [SW-1:0] bh [NCH][16];
  int bw = 0;
  logic [OW-1:0] expq [$];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_en = 1;
      for (int c = 0; c < NCH; c++) begin
        logic [SW-1:0] v = SW'($urandom);
        smp_data[c*SW +: SW] = v;
        bh[c][bw] = v;
      end
      bw = (bw + 1) % 16;
    end
    @(negedge clk);
    smp_en = 0;
  endtask

  task automatic build(input logic [63:0] m, input int lb);
    int eff = (lb < 9) ? 9 : lb;
    int cnt = 0;
    expq.push_back({2'b00, SW'(eff)});
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      expq.push_back({2'b01, SW'(c)});
      for (int i = 0; i < 10; i++)
        expq.push_back({2'b10, bh[c][(bw - 1 - eff + i + 32) % 16]});
      cnt++;
    end
    expq.push_back({2'b11, SW'(cnt)});
  endtask

  task automatic fire(input logic [63:0] m, input int lb);
    @(negedge clk);
    trig = 1; trig_mask = m; lookback = 4'(lb);
    @(negedge clk);
    trig = 0;
  endtask

  function automatic string tag(input logic [1:0] k);
    case (k)
      2'b00: return "R2 event-header";
      2'b01: return "R3 channel-header";
      2'b10: return "R4 sample";
      default: return "R2 trailer";
    endcase
  endfunction

  task automatic drain(input bit rnd, input string label);
    bit held = 0;
    logic [OW-1:0] hd = '0;
    while (expq.size() != 0) begin
      @(negedge clk);
      if (held) chk(out_valid && out_data == hd, "R7 held word", {out_valid, out_data}, {1'b1, hd});
      out_ready = rnd ? (($urandom % 4) != 0) : 1'b1;
      held = out_valid && !out_ready;
      hd = out_data;
      if (out_valid && out_ready) begin
        chk(out_data == expq[0], {label, " ", tag(expq[0][13:12])}, out_data, expq[0]);
        void'(expq.pop_front());
      end
    end
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 0, req, out_valid, 0);
  endtask

  initial begin
    logic [63:0] m;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 valid after reset", out_valid, 0);
    chk(overflow == 0, "R1 overflow after reset", overflow, 0);
    rst_n = 1;
    push(20);

    fire(64'h1, 12); build(64'h1, 12); drain(0, "R2 single ch0"); idle_chk("R2 idle after trailer");
    m = 64'h8000_0000_0001_0041;
    fire(m, 15); build(m, 15); drain(0, "R3 edges"); idle_chk("R3 idle");
    fire(64'h0000_0100_0000_0000, 3); build(64'h0000_0100_0000_0000, 3); drain(1, "R5 clamp 3->9");
    idle_chk("R5 idle");
    fire(64'h0, 11); build(64'h0, 11);
    chk(expq.size() == 2, "R6 expected length", expq.size(), 2);
    drain(1, "R6 empty pattern"); idle_chk("R6 idle after two words");
    fire('1, 9); build('1, 9); drain(1, "R7 all ones backpressure"); idle_chk("R7 idle");

    // R8/R9/R10: held trigger, discarded trigger, samples dropped during an event
    push(5);
    m = 64'h0000_0F00_0000_00F0;
    fire(m, 10); build(m, 10);
    fork
      drain(1, "R8 first+held");
      begin
        @(negedge clk); smp_en = 1; smp_data = '1;
        @(negedge clk); smp_en = 0;
        fire(64'h2000_0000_0000_0008, 4);
        build(64'h2000_0000_0000_0008, 4);
        chk(overflow == 0, "R9 no overflow when slot free", overflow, 0);
        fire(64'hFFFF, 14);
        chk(overflow == 1, "R9 overflow pulse", overflow, 1);
        @(negedge clk);
        chk(overflow == 0, "R9 overflow one cycle", overflow, 0);
      end
    join
    idle_chk("R9 discarded trigger produced no event");

    // R10: sample coinciding with an idle trigger is the newest
    @(negedge clk);
    smp_en = 1; trig = 1; trig_mask = 64'h10; lookback = 9;
    for (int c = 0; c < NCH; c++) begin
      logic [SW-1:0] v = SW'($urandom);
      smp_data[c*SW +: SW] = v;
      bh[c][bw] = v;
    end
    bw = (bw + 1) % 16;
    @(negedge clk);
    smp_en = 0; trig = 0;
    build(64'h10, 9); drain(0, "R10 trigger-cycle sample"); idle_chk("R10 idle");

    for (int it = 0; it < 20; it++) begin
      push(1 + $urandom % 20);
      m = {$urandom, $urandom} & {$urandom, $urandom};
      begin
        int lb = $urandom % 16;
        fire(m, lb); build(m, lb);
      end
      drain(1, "R4 random");
      idle_chk("R2 random idle");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule